// File: doc/BRIEF.md
# Predicated Compare Unit

This block evaluates one integer comparison per cycle and records the outcome in a file of one-bit predicates. The first operand is either a 64-bit register value or an 8-bit immediate. The second operand is always a 64-bit register value. The relation is tested as "first relation second". The outcome lands in two destination predicates. How it lands depends on the update type: normal (result and its complement), and-type (clear both on a false outcome) or or-type (set both on a true outcome).

The predicate file has 64 entries. Entry 0 is wired to one. Any number of read ports is available for qualifying predicates elsewhere in the pipeline. The compare has its own qualifying predicate, which is read from the same file. When that predicate is false, nothing is written.

Top module: `pred_cmp_unit`

## Requirements
- R1: Signed relations compare the operands as two's complement: code 2 tests less-than, 3 less-or-equal, 4 greater-than and 5 greater-or-equal. The outcome appears combinationally on `cmp_hit`.
- R2: Code 0 tests equality and code 1 inequality. Codes 6, 7, 8 and 9 test unsigned less-than, less-or-equal, greater-than and greater-or-equal. Codes 10 to 15 always give a false outcome.
- R3: When `cmp_use_imm` is 1, the first operand is `cmp_imm` sign-extended to 64 bits for every relation, signed or unsigned. Otherwise the first operand is `cmp_src_a`.
- R4: In update type 0 (normal), the first destination receives the outcome and the second receives its complement. If both destinations name the same entry, the first destination's value is kept.
- R5: In update type 2 (or-type), a true outcome sets both destinations to 1. A false outcome leaves the whole file unchanged.
- R6: In update type 1 (and-type), a false outcome clears both destinations to 0. A true outcome leaves the whole file unchanged.
- R7: No entry changes when `cmp_valid` is 0, or when the qualifying predicate selected by `cmp_qp` holds 0. Index 0 as a qualifying predicate is always true.
- R8: Entry 0 reads as 1 at all times, and any write aimed at it is discarded.
- R9: Writes take effect at the rising clock edge. A read in the same cycle as a write returns the value from before that write.
- R10: Update type 3 writes nothing.
- R11: After reset, entries 1 to 63 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_valid | input | 1 | A compare is issued this cycle |
| cmp_qp | input | 6 | Index of the compare's qualifying predicate |
| cmp_rel | input | 4 | Relation code |
| cmp_upd | input | 2 | Update type code |
| cmp_use_imm | input | 1 | Use the immediate as first operand |
| cmp_imm | input | 8 | Signed immediate |
| cmp_src_a | input | 64 | First register operand |
| cmp_src_b | input | 64 | Second register operand |
| cmp_dst1 | input | 6 | First destination predicate index |
| cmp_dst2 | input | 6 | Second destination predicate index |
| cmp_hit | output | 1 | Outcome of the relation |
| rd_idx | input | 12 | Packed read indices, 6 bits per port |
| rd_val | output | 2 | Read values, one per port |

## Verification
Operand pairs are drawn as independent random values, as equal values, as values that differ by one, and as values on either side of the sign bit. Together these separate the signed relations from the unsigned ones and separate strict relations from non-strict ones. Immediates near -1 and -128 against large unsigned values show whether sign extension is applied before unsigned tests. The qualifying predicate and the update type are drawn at random, so and-type and or-type operations hit both outcomes against a file whose contents vary. Same-index destinations and destinations at index 0 are forced in directed cases.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
    localparam int unsigned PIDX_W   = 6;
    localparam int unsigned NUM_PRED = 1 << PIDX_W;

    typedef enum logic [3:0] {
        REL_EQ  = 4'd0, REL_NE  = 4'd1,
        REL_LT  = 4'd2, REL_LE  = 4'd3, REL_GT  = 4'd4, REL_GE  = 4'd5,
        REL_LTU = 4'd6, REL_LEU = 4'd7, REL_GTU = 4'd8, REL_GEU = 4'd9
    } rel_e;

    typedef enum logic [1:0] {
        UPD_NORM = 2'd0, UPD_AND = 2'd1, UPD_OR = 2'd2, UPD_RSVD = 2'd3
    } upd_e;

    typedef struct packed {
        logic              we;
        logic [PIDX_W-1:0] idx;
        logic              val;
    } pwr_t;

    typedef struct packed {
        logic [NUM_PRED-1:0] pr;
    } pfile_t;
endpackage

// File: rtl/pcu_rel_eval.sv
module pcu_rel_eval
    import pcu_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [3:0]        rel,
    output logic              hit
);
    logic same_d, slt_d, ult_d;

    always_comb begin
        same_d = (opa == opb);
        slt_d  = ($signed(opa) < $signed(opb));
        ult_d  = (opa < opb);
        case (rel)
            REL_EQ:  hit = same_d;
            REL_NE:  hit = !same_d;
            REL_LT:  hit = slt_d;
            REL_LE:  hit = slt_d || same_d;
            REL_GT:  hit = !slt_d && !same_d;
            REL_GE:  hit = !slt_d;
            REL_LTU: hit = ult_d;
            REL_LEU: hit = ult_d || same_d;
            REL_GTU: hit = !ult_d && !same_d;
            REL_GEU: hit = !ult_d;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcu_upd_gen.sv
module pcu_upd_gen
    import pcu_pkg::*;
(
    input  logic              fire,
    input  logic [1:0]        upd,
    input  logic              hit,
    input  logic [PIDX_W-1:0] dst1,
    input  logic [PIDX_W-1:0] dst2,
    output pwr_t              w1,
    output pwr_t              w2
);
    logic en_d, v1_d, v2_d;

    always_comb begin
        en_d = 1'b0;
        v1_d = 1'b0;
        v2_d = 1'b0;
        case (upd)
            UPD_NORM: begin en_d = 1'b1; v1_d = hit;  v2_d = !hit; end
            UPD_AND:  begin en_d = !hit; v1_d = 1'b0; v2_d = 1'b0; end
            UPD_OR:   begin en_d = hit;  v1_d = 1'b1; v2_d = 1'b1; end
            default:  begin en_d = 1'b0; end
        endcase
        w1.we  = fire && en_d && (dst1 != '0);
        w1.idx = dst1;
        w1.val = v1_d;
        w2.we  = fire && en_d && (dst2 != '0);
        w2.idx = dst2;
        w2.val = v2_d;
    end
endmodule

// File: rtl/pcu_pred_file.sv
module pcu_pred_file
    import pcu_pkg::*;
#(
    parameter int unsigned NUM_RD = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  pwr_t                     w1,
    input  pwr_t                     w2,
    input  logic [PIDX_W-1:0]        qp_idx,
    output logic                     qp_val,
    input  logic [NUM_RD*PIDX_W-1:0] rd_idx,
    output logic [NUM_RD-1:0]        rd_val,
    output logic [NUM_PRED-1:0]      pr_bits
);
    localparam logic [NUM_PRED-1:0] RST_VAL = {{(NUM_PRED-1){1'b0}}, 1'b1};

    pfile_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (w2.we) st_d.pr[w2.idx] = w2.val;
        if (w1.we) st_d.pr[w1.idx] = w1.val;
        st_d.pr[0] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.pr <= RST_VAL;
        else        st_q    <= st_d;
    end

    assign qp_val  = (qp_idx == '0) ? 1'b1 : st_q.pr[qp_idx];
    assign pr_bits = st_q.pr;

    for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
        logic [PIDX_W-1:0] idx_w;
        assign idx_w     = rd_idx[g*PIDX_W +: PIDX_W];
        assign rd_val[g] = (idx_w == '0) ? 1'b1 : st_q.pr[idx_w];
    end
endmodule

// File: rtl/pred_cmp_unit.sv
module pred_cmp_unit
    import pcu_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned IMM_W  = 8,
    parameter int unsigned NUM_RD = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmp_valid,
    input  logic [PIDX_W-1:0]        cmp_qp,
    input  logic [3:0]               cmp_rel,
    input  logic [1:0]               cmp_upd,
    input  logic                     cmp_use_imm,
    input  logic [IMM_W-1:0]         cmp_imm,
    input  logic [DATA_W-1:0]        cmp_src_a,
    input  logic [DATA_W-1:0]        cmp_src_b,
    input  logic [PIDX_W-1:0]        cmp_dst1,
    input  logic [PIDX_W-1:0]        cmp_dst2,
    output logic                     cmp_hit,
    input  logic [NUM_RD*PIDX_W-1:0] rd_idx,
    output logic [NUM_RD-1:0]        rd_val
);
    localparam int unsigned EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0]   opa_w;
    logic                qp_ok;
    logic [NUM_PRED-1:0] pr_vec;
    pwr_t                w1, w2;

    assign opa_w = cmp_use_imm ? {{EXT_W{cmp_imm[IMM_W-1]}}, cmp_imm} : cmp_src_a;

    pcu_rel_eval #(.DATA_W(DATA_W)) u_rel (
        .opa (opa_w),
        .opb (cmp_src_b),
        .rel (cmp_rel),
        .hit (cmp_hit)
    );

    pcu_upd_gen u_upd (
        .fire (cmp_valid && qp_ok),
        .upd  (cmp_upd),
        .hit  (cmp_hit),
        .dst1 (cmp_dst1),
        .dst2 (cmp_dst2),
        .w1   (w1),
        .w2   (w2)
    );

    pcu_pred_file #(.NUM_RD(NUM_RD)) u_pf (
        .clk     (clk),
        .rst_n   (rst_n),
        .w1      (w1),
        .w2      (w2),
        .qp_idx  (cmp_qp),
        .qp_val  (qp_ok),
        .rd_idx  (rd_idx),
        .rd_val  (rd_val),
        .pr_bits (pr_vec)
    );
endmodule

// File: rtl/pred_cmp_unit_chk.sv
module pred_cmp_unit_chk
    import pcu_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                cmp_valid,
    input logic [1:0]          cmp_upd,
    input logic [PIDX_W-1:0]   cmp_dst1,
    input logic [PIDX_W-1:0]   cmp_dst2,
    input logic                cmp_hit,
    input logic                qp_ok,
    input logic [NUM_PRED-1:0] pr_now,
    input logic [PIDX_W-1:0]   rd0_idx,
    input logic                rd0_val
);
    logic go;
    assign go = cmp_valid && qp_ok;

    AST_NORM_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        go && cmp_upd == 2'd0 && cmp_dst1 != '0 |=> pr_now[$past(cmp_dst1)] == $past(cmp_hit)); // R4
    AST_NORM_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        go && cmp_upd == 2'd0 && cmp_dst2 != '0 && cmp_dst2 != cmp_dst1
        |=> pr_now[$past(cmp_dst2)] == !$past(cmp_hit)); // R4
    AST_OR_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        go && cmp_upd == 2'd2 && !cmp_hit |=> $stable(pr_now)); // R5
    AST_AND_HIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        go && cmp_upd == 2'd1 && cmp_hit |=> $stable(pr_now)); // R6
    AST_NO_FIRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> $stable(pr_now)); // R7
    AST_ZERO_READ_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        rd0_idx == '0 |-> rd0_val); // R8
    AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_upd == 2'd3 |=> $stable(pr_now)); // R10
endmodule

bind pred_cmp_unit pred_cmp_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_valid (cmp_valid),
    .cmp_upd   (cmp_upd),
    .cmp_dst1  (cmp_dst1),
    .cmp_dst2  (cmp_dst2),
    .cmp_hit   (cmp_hit),
    .qp_ok     (qp_ok),
    .pr_now    (pr_vec),
    .rd0_idx   (rd_idx[5:0]),
    .rd0_val   (rd_val[0])
);

// File: tb/test_pred_cmp_unit.sv
module test_pred_cmp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_valid = 1'b0;
    logic [5:0]  cmp_qp = '0;
    logic [3:0]  cmp_rel = '0;
    logic [1:0]  cmp_upd = '0;
    logic        cmp_use_imm = 1'b0;
    logic [7:0]  cmp_imm = '0;
    logic [63:0] cmp_src_a = '0;
    logic [63:0] cmp_src_b = '0;
    logic [5:0]  cmp_dst1 = '0;
    logic [5:0]  cmp_dst2 = '0;
    logic        cmp_hit;
    logic [11:0] rd_idx = '0;
    logic [1:0]  rd_val;

    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] mp;

    always #5 clk = ~clk;

    pred_cmp_unit i_pred_cmp_unit (.*);

    function automatic logic rel_ref(input logic [3:0] r, input logic [63:0] a, input logic [63:0] b);
        logic signed [63:0] sa, sb;
        sa = a; sb = b;
        case (r)
            4'd0: return a == b;
            4'd1: return a != b;
            4'd2: return sa < sb;
            4'd3: return sa <= sb;
            4'd4: return sa > sb;
            4'd5: return sa >= sb;
            4'd6: return a < b;
            4'd7: return a <= b;
            4'd8: return a > b;
            4'd9: return a >= b;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic pget(input logic [63:0] m, input logic [5:0] i);
        return (i == 0) ? 1'b1 : m[i];
    endfunction

    task automatic check(input logic got, input logic exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < 64; i += 2) begin
            @(negedge clk);
            rd_idx = {6'(i + 1), 6'(i)};
            #1;
            check(rd_val[0], pget(mp, 6'(i)), tag);
            check(rd_val[1], pget(mp, 6'(i + 1)), tag);
        end
    endtask

    task automatic do_op(input logic v, input logic [5:0] qp, input logic [3:0] rel,
                         input logic [1:0] upd, input logic ui, input logic [7:0] imm,
                         input logic [63:0] a, input logic [63:0] b,
                         input logic [5:0] d1, input logic [5:0] d2);
        logic [63:0] opa, nm;
        logic h, fire;
        string tag;
        @(negedge clk);
        cmp_valid = v; cmp_qp = qp; cmp_rel = rel; cmp_upd = upd;
        cmp_use_imm = ui; cmp_imm = imm; cmp_src_a = a; cmp_src_b = b;
        cmp_dst1 = d1; cmp_dst2 = d2;
        rd_idx = {d2, d1};
        #1;
        opa = ui ? {{56{imm[7]}}, imm} : a;
        h = rel_ref(rel, opa, b);
        tag = ui ? "R3" : ((rel >= 4'd2 && rel <= 4'd5) ? "R1" : "R2");
        check(cmp_hit, h, tag);
        check(rd_val[0], pget(mp, d1), "R9");
        check(rd_val[1], pget(mp, d2), "R9");
        fire = v && pget(mp, qp);
        nm = mp;
        if (fire) begin
            case (upd)
                2'd0: begin nm[d2] = !h; nm[d1] = h; end
                2'd1: if (!h) begin nm[d2] = 1'b0; nm[d1] = 1'b0; end
                2'd2: if (h)  begin nm[d2] = 1'b1; nm[d1] = 1'b1; end
                default: ;
            endcase
        end
        nm[0] = 1'b0;
        if (!fire) tag = "R7";
        else case (upd)
            2'd0: tag = "R4";
            2'd1: tag = "R6";
            2'd2: tag = "R5";
            default: tag = "R10";
        endcase
        @(posedge clk);
        #1;
        mp = nm;
        cmp_valid = 1'b0;
        #1;
        check(rd_val[0], pget(mp, d1), tag);
        check(rd_val[1], pget(mp, d2), tag);
    endtask

    function automatic logic [63:0] r64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] a, b;
        void'($urandom(32'd4242));
        mp = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        sweep("R11");

        // directed corner cases
        do_op(1, 0, 4'd0, 2'd0, 0, 0, 64'd5, 64'd5, 6'd3, 6'd4);           // R4 eq true
        do_op(1, 0, 4'd2, 2'd0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 6'd5, 6'd6); // R1 -1 < 1
        do_op(1, 0, 4'd6, 2'd0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 6'd7, 6'd8); // R2 unsigned
        do_op(1, 0, 4'd0, 2'd0, 1, 8'hFF, 0, 64'hFFFF_FFFF_FFFF_FFFF, 6'd9, 6'd10); // R3 sext
        do_op(1, 0, 4'd6, 2'd0, 1, 8'h80, 0, 64'd5, 6'd11, 6'd12);        // R3 unsigned of sext
        do_op(1, 0, 4'd12, 2'd0, 0, 0, 64'd1, 64'd1, 6'd13, 6'd14);       // R2 reserved code
        do_op(1, 0, 4'd0, 2'd0, 0, 0, 64'd1, 64'd2, 6'd15, 6'd15);        // R4 same index
        do_op(1, 0, 4'd0, 2'd0, 0, 0, 64'd1, 64'd2, 6'd0, 6'd0);          // R8 write to 0 discarded
        do_op(1, 0, 4'd1, 2'd2, 0, 0, 64'd1, 64'd1, 6'd3, 6'd4);          // R5 or miss
        do_op(1, 0, 4'd1, 2'd2, 0, 0, 64'd1, 64'd2, 6'd16, 6'd17);        // R5 or hit
        do_op(1, 0, 4'd0, 2'd1, 0, 0, 64'd1, 64'd1, 6'd16, 6'd17);        // R6 and hit
        do_op(1, 0, 4'd0, 2'd1, 0, 0, 64'd1, 64'd2, 6'd16, 6'd3);         // R6 and miss
        do_op(1, 6'd20, 4'd0, 2'd0, 0, 0, 64'd1, 64'd1, 6'd21, 6'd22);    // R7 qp false
        do_op(0, 0, 4'd0, 2'd0, 0, 0, 64'd1, 64'd1, 6'd21, 6'd22);        // R7 not valid
        do_op(1, 0, 4'd0, 2'd3, 0, 0, 64'd1, 64'd1, 6'd21, 6'd22);        // R10 reserved type
        rd_idx = '0;
        @(negedge clk); #1 check(rd_val[0], 1'b1, "R8");

        for (int k = 0; k < 600; k++) begin
            logic [3:0] rel;
            b = r64();
            case ($urandom % 5)
                0: a = b;
                1: a = b + 64'd1;
                2: a = b - 64'd1;
                3: a = {~b[63], b[62:0]};
                default: a = r64();
            endcase
            rel = ($urandom % 8 == 0) ? 4'($urandom) : 4'($urandom % 10);
            do_op(($urandom % 8) != 0, 6'($urandom % 8), rel, 2'($urandom),
                  ($urandom % 4) == 0, 8'($urandom), a, b,
                  6'($urandom % 12), 6'($urandom % 12));
        end
        sweep("R9");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule